// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is a synthesizable behavioural model of the command side of a parallel NOR flash. A host drives it with active-low chip enable, write enable and output enable, a word address and a 16-bit data bus. A small word array stands in for the cells. Writes never land in the array directly. A multi-cycle state machine decodes them. It recognises word program, sector erase, a bypass mode that shortens programming, and suspend and resume of a running erase.

Program and erase run for a fixed number of clock cycles, set by parameters. While one runs, every read returns a status word in place of array data. Bit 7 is a polling flag and bit 6 toggles on each read. Sectors can be protected one by one, and a low-supply input blocks all writes. Reads use an 8-word page. A new page costs extra cycles. Later reads in the same page return after one cycle.

Top module: `pflash_cmd`

## Requirements
- R1: After reset, rdValid is 0 and every word reads 0xFFFF, which is the erased state.
- R2: A program uses four write cycles: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then data at the target address. The word becomes the bitwise AND of its old value and the data.
- R3: A write cycle that does not match its step in a sequence returns the decoder to read mode. Writing 0xF0 while no operation runs also returns it to read mode, except in a data step. Read mode ignores any lone write.
- R4: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs the word. 0xF0 leaves bypass mode.
- R5: A program runs for PROG_CYC cycles and an erase for ERASE_CYC running cycles. While one runs, reads return a status word. Bits 15:8 and 5:0 are 0. Bit 7 is the inverse of data bit 7 for a program and 0 for an erase. When the operation ends, reads return array data again.
- R6: Bit 6 of the status word flips on every status read.
- R7: An erase uses six write cycles: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the sector. The sector is the top SECT_W address bits. The erase sets every word of that sector to 0xFFFF and leaves the other sectors unchanged.
- R8: Writing 0xB0 during a running erase holds it. While held, reads return array data, and words outside the erasing sector can be programmed. 0x30 written in read mode or bypass mode resumes the erase.
- R9: A program or erase aimed at a sector whose sectProt bit is 1 is ignored, and no status is shown.
- R10: While lowVcc is 1, every write cycle is ignored.
- R11: A read that opens a new 8-word page returns data INIT_LAT+2 cycles after the read is applied. A read in the open page returns data the next cycle.
- R12: While a program or running erase is busy, all writes are ignored except the 0xB0 suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low; one write per clock with ceN=0, weN=0, oeN=1 |
| oeN | input | 1 | Output enable, active low; a read is ceN=0, oeN=0, weN=1 |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Write data; commands use the low byte |
| lowVcc | input | 1 | Low-supply flag; blocks all writes |
| sectProt | input | 2**SECT_W | Protection bit for each sector |
| rdData | output | 16 | Read data or status word |
| rdValid | output | 1 | rdData holds a read result this cycle |

## Verification
The bench runs several command sequences:
- complete unlock sequences, which must program or erase;
- sequences with a wrong address or data in one step, and sequences cut short by 0xF0, which must leave the array unchanged;
- bypass sequences issued both before and after bypass mode is left, which shows whether the mode flag holds and is cleared.

Status is read back to back, both while a program runs and while an erase runs. This separates the polling bit of each operation from the toggle bit, and it checks that array data returns once the operation ends.

An erase is suspended and resumed around a program to a different sector. This test also tries a write to the erasing sector, a write to a protected sector and writes under lowVcc. Each of these must show through a later read-back, so that ignored writes are told apart from accepted ones.

// File: rtl/pflash_cmd_pkg.sv
package pflash_cmd_pkg;

  localparam int DATA_W = 16;

  localparam logic [10:0] UNLK_ADDR_1 = 11'h555;
  localparam logic [10:0] UNLK_ADDR_2 = 11'h2AA;

  localparam logic [7:0] KEY_1      = 8'hAA;
  localparam logic [7:0] KEY_2      = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_BYPASS  = 8'h20;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_HOLD    = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;

  typedef enum logic [3:0] {
    ST_READ,
    ST_KEY1,
    ST_CMD,
    ST_PDATA,
    ST_EKEY0,
    ST_EKEY1,
    ST_ESECT,
    ST_BYP,
    ST_BDATA
  } cmdState_e;

  typedef struct packed {
    logic progCommit;
    logic eraseCommit;
    logic statusOn;
    logic pollBit;
  } ctrlStb_t;

endpackage

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrStb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [(1<<SECT_W)-1:0]  sectProt,
  output ctrlStb_t                stb,
  output logic [ADDR_W-1:0]       opAddr,
  output logic [DATA_W-1:0]       opData,
  output logic [SECT_W-1:0]       opSect
);

  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);

  cmdState_e         state, stateNxt;
  logic              bypass, bypassNxt;
  logic              progBusy;
  logic [PCW-1:0]    progCnt;
  logic              eraseBusy, eraseHeld;
  logic [ECW-1:0]    eraseCnt;
  logic              progStart, eraseStart, holdNow, resumeNow;

  logic [7:0]        cmdByte;
  logic              atKey1, atKey2;
  logic [SECT_W-1:0] tgtSect;
  logic              busy, progOk, eraseOk;

  assign cmdByte = wrData[7:0];
  assign atKey1  = (addr[10:0] == UNLK_ADDR_1);
  assign atKey2  = (addr[10:0] == UNLK_ADDR_2);
  assign tgtSect = addr[ADDR_W-1 -: SECT_W];
  assign busy    = progBusy | (eraseBusy & ~eraseHeld);
  assign progOk  = ~sectProt[tgtSect] & ~(eraseBusy & (tgtSect == opSect));
  assign eraseOk = ~sectProt[tgtSect] & ~eraseBusy;

  always_comb begin
    stateNxt   = state;
    bypassNxt  = bypass;
    progStart  = 1'b0;
    eraseStart = 1'b0;
    holdNow    = 1'b0;
    resumeNow  = 1'b0;
    if (wrStb) begin
      if (busy) begin
        if (eraseBusy && !eraseHeld && !progBusy && cmdByte == OP_HOLD &&
            eraseCnt != ECW'(1))
          holdNow = 1'b1;
      end else if (cmdByte == OP_RESET && state != ST_PDATA && state != ST_BDATA) begin
        stateNxt  = ST_READ;
        bypassNxt = 1'b0;
      end else begin
        unique case (state)
          ST_READ: begin
            if (eraseHeld && cmdByte == OP_RESUME) resumeNow = 1'b1;
            else if (atKey1 && cmdByte == KEY_1)   stateNxt  = ST_KEY1;
          end
          ST_KEY1:  stateNxt = (atKey2 && cmdByte == KEY_2) ? ST_CMD : ST_READ;
          ST_CMD: begin
            stateNxt = ST_READ;
            if (atKey1) begin
              if (cmdByte == OP_PROGRAM)    stateNxt = ST_PDATA;
              else if (cmdByte == OP_ERASE) stateNxt = ST_EKEY0;
              else if (cmdByte == OP_BYPASS) begin
                stateNxt  = ST_BYP;
                bypassNxt = 1'b1;
              end
            end
          end
          ST_PDATA: begin
            progStart = progOk;
            stateNxt  = ST_READ;
          end
          ST_EKEY0: stateNxt = (atKey1 && cmdByte == KEY_1) ? ST_EKEY1 : ST_READ;
          ST_EKEY1: stateNxt = (atKey2 && cmdByte == KEY_2) ? ST_ESECT : ST_READ;
          ST_ESECT: begin
            eraseStart = (cmdByte == OP_SECTOR) & eraseOk;
            stateNxt   = ST_READ;
          end
          ST_BYP: begin
            if (eraseHeld && cmdByte == OP_RESUME) resumeNow = 1'b1;
            else if (cmdByte == OP_PROGRAM)        stateNxt  = ST_BDATA;
          end
          ST_BDATA: begin
            progStart = progOk;
            stateNxt  = ST_BYP;
          end
          default: stateNxt = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_READ;
      bypass   <= 1'b0;
      progBusy <= 1'b0;
      progCnt  <= '0;
      opAddr   <= '0;
      opData   <= '0;
    end else begin
      state  <= stateNxt;
      bypass <= bypassNxt;
      if (progStart) begin
        progBusy <= 1'b1;
        progCnt  <= PCW'(PROG_CYC);
        opAddr   <= addr;
        opData   <= wrData;
      end else if (progBusy) begin
        if (progCnt == PCW'(1)) progBusy <= 1'b0;
        progCnt <= progCnt - PCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusy <= 1'b0;
      eraseHeld <= 1'b0;
      eraseCnt  <= '0;
      opSect    <= '0;
    end else if (eraseStart) begin
      eraseBusy <= 1'b1;
      eraseHeld <= 1'b0;
      eraseCnt  <= ECW'(ERASE_CYC);
      opSect    <= tgtSect;
    end else if (holdNow) begin
      eraseHeld <= 1'b1;
    end else if (resumeNow) begin
      eraseHeld <= 1'b0;
    end else if (eraseBusy && !eraseHeld) begin
      if (eraseCnt == ECW'(1)) eraseBusy <= 1'b0;
      eraseCnt <= eraseCnt - ECW'(1);
    end
  end

  assign stb.progCommit  = progBusy & (progCnt == PCW'(1));
  assign stb.eraseCommit = eraseBusy & ~eraseHeld & (eraseCnt == ECW'(1));
  assign stb.statusOn    = busy;
  assign stb.pollBit     = progBusy ? ~opData[7] : 1'b0;

endmodule

// File: rtl/pflash_cmd_store.sv
module pflash_cmd_store
  import pflash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 2,
  parameter int PAGE_W   = 3,
  parameter int INIT_LAT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdReq,
  input  logic [ADDR_W-1:0]  addr,
  input  ctrlStb_t           stb,
  input  logic [ADDR_W-1:0]  opAddr,
  input  logic [DATA_W-1:0]  opData,
  input  logic [SECT_W-1:0]  opSect,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid
);

  localparam int NUM_SECT   = 1 << SECT_W;
  localparam int SECT_AW    = ADDR_W - SECT_W;
  localparam int SECT_WORDS = 1 << SECT_AW;
  localparam int TAG_W      = ADDR_W - PAGE_W;
  localparam int LCW        = $clog2(INIT_LAT + 1);

  logic [DATA_W-1:0] sectRd [NUM_SECT];

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic [DATA_W-1:0] bank [SECT_WORDS];
    logic eraseHere, progHere;

    assign eraseHere = stb.eraseCommit & (opSect == SECT_W'(s));
    assign progHere  = stb.progCommit & (opAddr[ADDR_W-1 -: SECT_W] == SECT_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < SECT_WORDS; w++) bank[w] <= '1;
      end else if (eraseHere) begin
        for (int w = 0; w < SECT_WORDS; w++) bank[w] <= '1;
      end else if (progHere) begin
        bank[opAddr[SECT_AW-1:0]] <= bank[opAddr[SECT_AW-1:0]] & opData;
      end
    end

    assign sectRd[s] = bank[addr[SECT_AW-1:0]];
  end

  logic             pageOpen, toggleQ, pageHit, hit;
  logic [TAG_W-1:0] openTag, curTag;
  logic [LCW-1:0]   latCnt;
  logic [DATA_W-1:0] statusWord, arrayWord;

  assign curTag     = addr[ADDR_W-1:PAGE_W];
  assign pageHit    = pageOpen & (openTag == curTag);
  assign hit        = rdReq & pageHit & (latCnt == '0);
  assign arrayWord  = sectRd[addr[ADDR_W-1 -: SECT_W]];
  assign statusWord = {8'h00, stb.pollBit, toggleQ, 6'h00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageOpen <= 1'b0;
      openTag  <= '0;
      latCnt   <= '0;
    end else if (rdReq && !pageHit) begin
      pageOpen <= 1'b1;
      openTag  <= curTag;
      latCnt   <= LCW'(INIT_LAT);
    end else if (latCnt != '0) begin
      latCnt <= latCnt - LCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else begin
      rdValid <= hit;
      if (hit) begin
        if (stb.statusOn) begin
          rdData  <= statusWord;
          toggleQ <= ~toggleQ;
        end else begin
          rdData <= arrayWord;
        end
      end
    end
  end

endmodule

// File: rtl/pflash_cmd.sv
module pflash_cmd
  import pflash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 2,
  parameter int PAGE_W    = 3,
  parameter int INIT_LAT  = 2,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ceN,
  input  logic                   weN,
  input  logic                   oeN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [15:0]            wrData,
  input  logic                   lowVcc,
  input  logic [(1<<SECT_W)-1:0] sectProt,
  output logic [15:0]            rdData,
  output logic                   rdValid
);

  logic              wrStb, rdReq;
  ctrlStb_t          stb;
  logic [ADDR_W-1:0] opAddr;
  logic [15:0]       opData;
  logic [SECT_W-1:0] opSect;

  assign wrStb = ~ceN & ~weN & oeN & ~lowVcc;
  assign rdReq = ~ceN & ~oeN & weN;

  pflash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .addr(addr), .wrData(wrData),
    .sectProt(sectProt), .stb(stb), .opAddr(opAddr), .opData(opData), .opSect(opSect)
  );

  pflash_cmd_store #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W), .INIT_LAT(INIT_LAT)
  ) u_store (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .addr(addr), .stb(stb),
    .opAddr(opAddr), .opData(opData), .opSect(opSect),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/pflash_cmd_chk.sv
module pflash_cmd_chk
  import pflash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 2,
  parameter int PAGE_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rdReq,
  input logic [ADDR_W-1:0]      addr,
  input logic [(1<<SECT_W)-1:0] sectProt,
  input ctrlStb_t               stb,
  input logic [ADDR_W-1:0]      opAddr,
  input logic [SECT_W-1:0]      opSect,
  input logic [15:0]            rdData,
  input logic                   rdValid
);

  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(stb.statusOn) |-> (rdData[15:8] == 8'h00) && (rdData[5:0] == 6'h00)); // R5

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(rdValid) && $past(stb.statusOn) && $past(stb.statusOn, 2)
    |-> rdData[6] != $past(rdData[6])); // R6

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.progCommit && stb.eraseCommit)); // R8

  AST_PROT_PROGRAM: assert property (@(posedge clk) disable iff (!rstN)
    stb.progCommit |-> !sectProt[opAddr[ADDR_W-1 -: SECT_W]]); // R9

  AST_PROT_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseCommit |-> !sectProt[opSect]); // R9

  AST_PAGE_MISS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && $past(rdReq) && (addr[ADDR_W-1:PAGE_W] != $past(addr[ADDR_W-1:PAGE_W]))
    |=> !rdValid); // R11

endmodule

bind pflash_cmd pflash_cmd_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .addr(addr), .sectProt(sectProt),
  .stb(stb), .opAddr(opAddr), .opSect(opSect), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/pflash_cmd_bench.sv
module pflash_cmd_bench;

  localparam int INIT_LAT  = 2;
  localparam int PROG_CYC  = 20;
  localparam int ERASE_CYC = 60;
  localparam int WORDS     = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] wrData = '0;
  logic        lowVcc = 1'b0;
  logic [3:0]  sectProt = '0;
  logic [15:0] rdData;
  logic        rdValid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  pflash_cmd u_pflash_cmd (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .wrData(wrData), .lowVcc(lowVcc), .sectProt(sectProt),
    .rdData(rdData), .rdValid(rdValid)
  );

  // ---------------- behavioural reference model ----------------
  localparam int M_READ = 0, M_KEY1 = 1, M_CMD = 2, M_PDATA = 3, M_EK0 = 4,
                 M_EK1 = 5, M_ESECT = 6, M_BYP = 7, M_BDATA = 8;

  logic [15:0] mMem [WORDS];
  int  mSt, mByp;
  bit  pBusy, eBusy, eHeld, pOpen, tog, mValid;
  int  pCnt, eCnt, eSect, oPage, lat;
  logic [10:0] pA;
  logic [15:0] pD, mData;

  function automatic bit progAllowed(int sec);
    return !sectProt[sec] && !(eBusy && sec == eSect);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mMem[i] = 16'hFFFF;
      mSt = M_READ; mByp = 0; pBusy = 0; eBusy = 0; eHeld = 0; pOpen = 0;
      tog = 0; mValid = 0; pCnt = 0; eCnt = 0; eSect = 0; oPage = 0; lat = 0;
      mData = '0; pA = '0; pD = '0;
    end else begin
      bit wq, rq, stat, skipP, skipE, nValid;
      logic [15:0] nData;
      logic [7:0] lo;
      int sec, pg;
      wq = !ceN && !weN && oeN && !lowVcc;
      rq = !ceN && !oeN && weN;
      stat = pBusy || (eBusy && !eHeld);
      pg = int'(addr) >> 3;
      nValid = 0; nData = mData;
      if (rq && pOpen && oPage == pg && lat == 0) begin
        nValid = 1;
        if (stat) begin
          nData = {8'h00, pBusy ? ~pD[7] : 1'b0, tog, 6'h00};
          tog = !tog;
        end else nData = mMem[addr];
      end
      if (rq && !(pOpen && oPage == pg)) begin pOpen = 1; oPage = pg; lat = INIT_LAT; end
      else if (lat != 0) lat--;
      mValid = nValid; mData = nData;

      skipP = 0; skipE = 0;
      lo = wrData[7:0]; sec = int'(addr) >> 9;
      if (wq) begin
        if (stat) begin
          if (eBusy && !eHeld && !pBusy && lo == 8'hB0 && eCnt != 1) eHeld = 1;
        end else if (lo == 8'hF0 && mSt != M_PDATA && mSt != M_BDATA) begin
          mSt = M_READ; mByp = 0;
        end else begin
          case (mSt)
            M_READ: if (eHeld && lo == 8'h30) begin eHeld = 0; skipE = 1; end
                    else if (addr == 11'h555 && lo == 8'hAA) mSt = M_KEY1;
            M_KEY1: mSt = (addr == 11'h2AA && lo == 8'h55) ? M_CMD : M_READ;
            M_CMD: begin
              mSt = M_READ;
              if (addr == 11'h555 && lo == 8'hA0) mSt = M_PDATA;
              else if (addr == 11'h555 && lo == 8'h80) mSt = M_EK0;
              else if (addr == 11'h555 && lo == 8'h20) begin mSt = M_BYP; mByp = 1; end
            end
            M_PDATA, M_BDATA: begin
              if (progAllowed(sec)) begin
                pBusy = 1; pCnt = PROG_CYC; pA = addr; pD = wrData; skipP = 1;
              end
              mSt = (mSt == M_BDATA) ? M_BYP : M_READ;
            end
            M_EK0: mSt = (addr == 11'h555 && lo == 8'hAA) ? M_EK1 : M_READ;
            M_EK1: mSt = (addr == 11'h2AA && lo == 8'h55) ? M_ESECT : M_READ;
            M_ESECT: begin
              if (lo == 8'h30 && !sectProt[sec] && !eBusy) begin
                eBusy = 1; eHeld = 0; eCnt = ERASE_CYC; eSect = sec; skipE = 1;
              end
              mSt = M_READ;
            end
            M_BYP: if (eHeld && lo == 8'h30) begin eHeld = 0; skipE = 1; end
                   else if (lo == 8'hA0) mSt = M_BDATA;
            default: mSt = M_READ;
          endcase
        end
      end
      if (pBusy && !skipP) begin
        if (pCnt == 1) begin mMem[pA] = mMem[pA] & pD; pBusy = 0; end
        pCnt--;
      end
      if (eBusy && !eHeld && !skipE && !(wq && stat && eHeld)) begin
        if (eCnt == 1) begin
          for (int i = 0; i < 512; i++) mMem[eSect*512 + i] = 16'hFFFF;
          eBusy = 0;
        end
        eCnt--;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      total++;
      if (rdValid !== mValid || (mValid && rdData !== mData)) begin
        bad++;
        $display("FAIL %s per-cycle: act valid=%b data=%h exp valid=%b data=%h",
                 curReq, rdValid, rdData, mValid, mData);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    ceN = 0; weN = 0; oeN = 1; addr = a; wrData = d;
    @(negedge clk);
    ceN = 1; weN = 1;
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase(input logic [10:0] a);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, 16'h0030);
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d, output int n);
    @(negedge clk);
    ceN = 0; oeN = 0; weN = 1; addr = a;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      n++;
      if (rdValid) break;
    end
    d = rdData;
    ceN = 1; oeN = 1;
  endtask

  task automatic rd2(input logic [10:0] a, output logic [15:0] d1, output logic [15:0] d2);
    @(negedge clk);
    ceN = 0; oeN = 0; weN = 1; addr = a;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (rdValid) break;
    end
    d1 = rdData;
    @(negedge clk);
    d2 = rdData;
    ceN = 1; oeN = 1;
  endtask

  task automatic expectWord(input string tag, input logic [10:0] a, input logic [15:0] e);
    logic [15:0] d;
    int n;
    rd(a, d, n);
    chk(tag, d, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [15:0] d1, d2;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";
    @(negedge clk);
    chk("R1 rdValid after reset", rdValid, 0);
    expectWord("R1 erased word low", 11'h000, 16'hFFFF);
    expectWord("R1 erased word high", 11'h7FF, 16'hFFFF);

    curReq = "R11";
    rd(11'h100, d1, n);
    chk("R11 new page latency", n, INIT_LAT + 2);
    rd(11'h105, d1, n);
    chk("R11 same page latency", n, 1);

    curReq = "R2";
    prog(11'h010, 16'h1234);
    rd2(11'h010, d1, d2);
    chk("R5 program poll word", d1 & 16'hFFBF, 16'h0080);
    chk("R6 toggle flips", d1[6] ^ d2[6], 1);
    idle(PROG_CYC + 2);
    expectWord("R2 program stores data", 11'h010, 16'h1234);
    prog(11'h010, 16'h00FF);
    idle(PROG_CYC + 2);
    expectWord("R2 program ANDs with old", 11'h010, 16'h0034);

    curReq = "R12";
    prog(11'h020, 16'h1111);
    prog(11'h030, 16'h2222);
    idle(PROG_CYC + 2);
    expectWord("R12 first program kept", 11'h020, 16'h1111);
    expectWord("R12 write during busy ignored", 11'h030, 16'hFFFF);

    curReq = "R3";
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h040, 16'h0000);
    idle(PROG_CYC + 2);
    expectWord("R3 wrong unlock aborts", 11'h040, 16'hFFFF);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h000, 16'h00F0);
    wr(11'h555, 16'h00A0); wr(11'h041, 16'h0000);
    idle(PROG_CYC + 2);
    expectWord("R3 reset command aborts", 11'h041, 16'hFFFF);

    curReq = "R4";
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0); wr(11'h050, 16'hBEEF);
    idle(PROG_CYC + 2);
    expectWord("R4 bypass program one", 11'h050, 16'hBEEF);
    wr(11'h3FF, 16'h00A0); wr(11'h051, 16'h0F0F);
    idle(PROG_CYC + 2);
    expectWord("R4 bypass program two", 11'h051, 16'h0F0F);
    wr(11'h000, 16'h00F0);
    wr(11'h000, 16'h00A0); wr(11'h052, 16'h0000);
    idle(PROG_CYC + 2);
    expectWord("R4 bypass left after reset", 11'h052, 16'hFFFF);

    curReq = "R7";
    prog(11'h210, 16'hAAAA);
    idle(PROG_CYC + 2);
    erase(11'h000);
    rd(11'h300, d1, n);
    chk("R5 erase poll word", d1 & 16'hFFBF, 16'h0000);
    idle(ERASE_CYC + 2);
    expectWord("R7 erased word a", 11'h010, 16'hFFFF);
    expectWord("R7 erased word b", 11'h050, 16'hFFFF);
    expectWord("R7 other sector kept", 11'h210, 16'hAAAA);

    curReq = "R8";
    erase(11'h200);
    idle(8);
    wr(11'h000, 16'h00B0);
    idle(2);
    expectWord("R8 array readable while held", 11'h210, 16'hAAAA);
    prog(11'h450, 16'h5A5A);
    idle(PROG_CYC + 2);
    expectWord("R8 program during hold", 11'h450, 16'h5A5A);
    prog(11'h210, 16'h0000);
    idle(PROG_CYC + 2);
    expectWord("R8 erasing sector not programmed", 11'h210, 16'hAAAA);
    wr(11'h000, 16'h0030);
    rd(11'h460, d1, n);
    chk("R8 status after resume", d1 & 16'hFFBF, 16'h0000);
    idle(ERASE_CYC + 2);
    expectWord("R8 erase finished", 11'h210, 16'hFFFF);
    expectWord("R8 other program kept", 11'h450, 16'h5A5A);

    curReq = "R9";
    prog(11'h610, 16'h1357);
    idle(PROG_CYC + 2);
    sectProt = 4'b1000;
    prog(11'h611, 16'h0000);
    idle(2);
    expectWord("R9 no status on protected program", 11'h610, 16'h1357);
    idle(PROG_CYC);
    expectWord("R9 protected program ignored", 11'h611, 16'hFFFF);
    erase(11'h600);
    idle(ERASE_CYC + 2);
    expectWord("R9 protected erase ignored", 11'h610, 16'h1357);
    sectProt = 4'b0000;

    curReq = "R10";
    lowVcc = 1'b1;
    prog(11'h700, 16'h0000);
    idle(PROG_CYC + 2);
    lowVcc = 1'b0;
    expectWord("R10 low supply blocks write", 11'h700, 16'hFFFF);
    prog(11'h700, 16'h8001);
    idle(PROG_CYC + 2);
    expectWord("R10 writes accepted after", 11'h700, 16'h8001);

    idle(4);
    finishRun();
  end

endmodule